// File: doc/BRIEF.md
# Configurable Flash Status Pin Generator

This block drives the single active-low status pin of a flash memory's write state machine. After reset the pin is a plain ready/busy level: it sits low for as long as the write state machine reports busy, so an external memory controller can hold off accesses. The host can instead turn the pin into an interrupt source. In that style the pin idles high and gives one low pulse of fixed width when an erase finishes, when a program finishes, or when either finishes.

The host picks the style with a two-write command sequence on a simple command/data write port. The first write carries the configuration command byte B8h. The next write carries the configuration byte, and only its two low bits count. The write state machine side supplies a busy level and one-cycle completion strobes for erase and for program. The pulse width is a cycle count. By default it is derived from the clock frequency so that it is close to 250 ns.

Top module: `flash_sts_pin`

## Requirements
- R1: While reset is asserted and after it is released, the mode is level mode (code 00), no command is pending, no pulse is active, and `sts_n` equals the inverse of `wsm_busy`.
- R2: A write whose low byte is B8h, followed by the next write (any later cycle with `wr_en` high), loads bits 1:0 of that second write as the mode code. Bits 7:2 have no effect. A second byte of B8h therefore selects code 00.
- R3: A write whose low byte is not B8h while no command is pending changes nothing, and the write that follows it is not taken as a configuration byte.
- R4: In level mode (code 00), `sts_n` is low in every cycle in which `wsm_busy` is high and high otherwise. The completion strobes have no effect in this mode.
- R5: In code 01, an `erase_done` strobe starts a pulse and a `prog_done` strobe does not.
- R6: In code 10, a `prog_done` strobe starts a pulse and an `erase_done` strobe does not.
- R7: In code 11, either strobe starts a pulse.
- R8: In any pulse mode (codes 01, 10, 11), `sts_n` is low for exactly PULSE_CYCLES cycles, starting in the cycle after the qualifying strobe, and high at all other times. `wsm_busy` is ignored in these modes.
- R9: A qualifying strobe that arrives during a pulse restarts the count, so `sts_n` stays low for a full PULSE_CYCLES cycles measured from the cycle after the new strobe.
- R10: A configuration byte that changes the mode ends any active pulse at once, and the new mode drives `sts_n` from the next cycle. A configuration byte that rewrites the current code leaves a running pulse undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | DATA_W | Host write data: the command byte or the configuration byte |
| wsm_busy | input | 1 | Write state machine busy level |
| erase_done | input | 1 | One-cycle strobe when an erase completes |
| prog_done | input | 1 | One-cycle strobe when a program completes |
| sts_n | output | 1 | Active-low status pin |

## Verification
The bench builds the block with PULSE_CYCLES set to 3 and keeps an 8-bit data path. A width of 3 lets the bench check the exact cycle in which each pulse ends. It also lets a second strobe land inside a running pulse, so the restart can be told apart from the original expiry. The pulse-cancel cases, both for a changed code and for a rewritten identical code, then fit in a few cycles. The bench also walks the reserved-bit masking, a B8h written as the data byte, and a reset applied while a pulse is active. The 63-cycle default width derived from a 250 MHz clock is only elaborated and is not walked by the bench.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;

  localparam logic [7:0] CFG_CMD_BYTE = 8'hB8;

  typedef enum logic [1:0] {
    STS_LEVEL    = 2'b00,
    STS_ON_ERASE = 2'b01,
    STS_ON_PROG  = 2'b10,
    STS_ON_EITHER = 2'b11
  } sts_mode_t;

endpackage

// File: rtl/flash_sts_rst_sync.sv
module flash_sts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/flash_sts_cfg_port.sv
module flash_sts_cfg_port
  import flash_sts_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output sts_mode_t         mode,
  output logic              mode_change
);

  logic      armed_q, armed_d;
  sts_mode_t mode_q, mode_d;
  logic      take_cfg;

  // next-state
  always_comb begin
    armed_d  = armed_q;
    mode_d   = mode_q;
    take_cfg = wr_en && armed_q;
    if (take_cfg) begin
      armed_d = 1'b0;
      mode_d  = sts_mode_t'(wr_data[1:0]);   // bits 7:2 reserved, dropped
    end else if (wr_en && (wr_data[7:0] == CFG_CMD_BYTE)) begin
      armed_d = 1'b1;
    end
  end

  assign mode_change = take_cfg && (wr_data[1:0] != mode_q);

  // registers, enabled only on host writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= STS_LEVEL;
    end else if (wr_en) begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
    end
  end

  assign mode = mode_q;

  // R2: the mode only moves on the cycle after a host write
  a_r2_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(wr_en))
    else $error("mode changed without a host write");

  // R3: a non-command write with nothing pending never arms the decoder
  a_r3_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed_q && wr_data[7:0] != CFG_CMD_BYTE) |=> !armed_q && $stable(mode_q))
    else $error("stray write affected decoder");

endmodule

// File: rtl/flash_sts_pulse_timer.sv
module flash_sts_pulse_timer #(
  parameter int PULSE_CYCLES = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic abort,
  output logic active
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = abort || trig || (cnt_q != '0);
    if (abort)               cnt_d = '0;
    else if (trig)           cnt_d = FULL;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R8: the count never exceeds the configured width
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL)
    else $error("pulse counter overran");

  // R9: a trigger always reloads a full width, even mid-pulse
  a_r9_full_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !abort) |=> (cnt_q == FULL))
    else $error("trigger did not reload full width");

  // R10: a cancel leaves no pulse behind
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active)
    else $error("pulse survived a mode change");

endmodule

// File: rtl/flash_sts_pin.sv
module flash_sts_pin
  import flash_sts_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLK_FREQ_MHZ = 250,
  parameter int PULSE_NS     = 250,
  parameter int PULSE_CYCLES = (CLK_FREQ_MHZ * PULSE_NS + 999) / 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wsm_busy,
  input  logic              erase_done,
  input  logic              prog_done,
  output logic              sts_n
);

  logic      rst_q_n;
  sts_mode_t mode;
  logic      mode_change;
  logic      pulse_trig;
  logic      pulse_active;

  flash_sts_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  flash_sts_cfg_port #(.DATA_W(DATA_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .mode        (mode),
    .mode_change (mode_change)
  );

  // event qualification by the current mode bits: bit0 erase, bit1 program
  always_comb begin
    pulse_trig = (mode[0] && erase_done) || (mode[1] && prog_done);
  end

  flash_sts_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .trig   (pulse_trig),
    .abort  (mode_change),
    .active (pulse_active)
  );

  always_comb begin
    if (mode == STS_LEVEL) sts_n = !wsm_busy;
    else                   sts_n = !pulse_active;
  end

  // R4: level mode holds the pin low for the whole busy time
  a_r4_busy_low: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode == STS_LEVEL && wsm_busy) |-> !sts_n)
    else $error("busy not shown in level mode");

  // R5: erase-only mode ignores program completion
  a_r5_prog_ignored: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode == STS_ON_ERASE && prog_done && !erase_done && !pulse_active && !mode_change)
      |=> sts_n)
    else $error("program completion pulsed in erase mode");

  // R6: program-only mode ignores erase completion
  a_r6_erase_ignored: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode == STS_ON_PROG && erase_done && !prog_done && !pulse_active && !mode_change)
      |=> sts_n)
    else $error("erase completion pulsed in program mode");

  // R8: in pulse modes the pin idles high when no event was seen
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode != STS_LEVEL && !pulse_trig && !pulse_active) |=>
      (mode == STS_LEVEL) || sts_n)
    else $error("pin low without a pulse");

endmodule

// File: tb/flash_sts_pin_test.sv
module flash_sts_pin_test;

  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wsm_busy, erase_done, prog_done;
  logic [7:0] wr_data;
  logic       sts_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  flash_sts_pin #(.DATA_W(8), .PULSE_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .prog_done(prog_done),
    .sts_n(sts_n)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] data;
    logic       busy;
    logic       ed;
    logic       pd;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // each row: inputs for one cycle, expected sts_n seen in that same cycle
  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // 0  R1 idle high
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // 1  R4 busy -> low
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4},  // 2  R4
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4},  // 3  R4 strobes no effect
    '{1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // 4  R4 strobes gave no pulse
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // 5  R3 stray then data
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // 6  R3 still level
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 7  R2 command
    '{1'b1, 8'hFD, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 8  R2 FDh -> code 01
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // 9  R8 busy ignored
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // 10 R5 prog strobe
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},  // 11 R5 no pulse
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5},  // 12 R5 erase strobe
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // 13 R5 pulse
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // 14 R8
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // 15 R8 last low cycle
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // 16 R8 ends after W
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 17 R2
    '{1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 18 R2 code 10
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},  // 19 R6 erase strobe
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // 20 R6 no pulse
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // 21 R6 prog strobe
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // 22 R6 pulse
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // 23 R8
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // 24 R8
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // 25 R8
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 26 R2
    '{1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 27 R2 code 11
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // 28 R7 erase strobe
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // 29 R7 pulse
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7},  // 30 R7 prog strobe mid-pulse
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // 31 R9 restarted
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // 32 R9 old pulse would end
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // 33 R9
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // 34 R9 ends
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // 35 R7 strobe
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // 36 R10 command mid-pulse
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // 37 R10 new code 01
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}, // 38 R10 cancelled
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10}, // 39 R10 strobe
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // 40 R10
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // 41 R10 same code
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // 42 R10 pulse kept
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}, // 43 R10 normal end
    '{1'b1, 8'hB8, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10}, // 44 R10 cmd + strobe
    '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // 45 R10 to level
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}, // 46 R10 level at once
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // 47 R4
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 48 R2
    '{1'b1, 8'hB8, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // 49 R2 B8h as data -> 00
    '{1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // 50 R3 not armed
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}   // 51 R3 still level
  };

  task automatic drive(input logic we, input logic [7:0] d, input logic b,
                       input logic e, input logic p);
    @(negedge clk);
    wr_en = we; wr_data = d; wsm_busy = b; erase_done = e; prog_done = p;
    #1;
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (sts_n !== exp) begin
      fails++;
      $display("FAIL %s: sts_n=%b expected %b at %0t", tag, sts_n, exp, $time);
    end
  endtask

  initial begin
    wr_en = 0; wr_data = '0; wsm_busy = 0; erase_done = 0; prog_done = 0;
    rst_n = 0;
    #1;
    check(1'b1, "R1 in reset, idle");
    wsm_busy = 1; #1;
    check(1'b0, "R1 in reset, busy");
    wsm_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].data, VECS[i].busy, VECS[i].ed, VECS[i].pd);
      checks++;
      if (sts_n !== VECS[i].exp) begin
        fails++;
        $display("FAIL R%0d vector %0d: sts_n=%b expected %b",
                 VECS[i].req, i, sts_n, VECS[i].exp);
      end
    end

    // directed: reset while a pulse runs in code 11
    drive(1, 8'hB8, 0, 0, 0);
    drive(1, 8'h03, 0, 0, 0);
    drive(0, 8'h00, 0, 0, 1);
    drive(0, 8'h00, 0, 0, 0);
    check(1'b0, "R7 pulse before reset");
    rst_n = 0; #1;
    check(1'b1, "R1 reset clears pulse");
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    drive(0, 8'h00, 1, 0, 0);
    check(1'b0, "R1 level mode after reset");
    drive(0, 8'h00, 0, 1, 1);
    drive(0, 8'h00, 0, 0, 0);
    check(1'b1, "R4 strobes ignored after reset");
    drive(1, 8'h07, 0, 0, 0);
    drive(0, 8'h00, 1, 0, 0);
    check(1'b0, "R3 lone data write ignored");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule